// File: doc/BRIEF.md
# Flash Program/Erase Control Interlock

This block is the control register that sits in front of a flash array during a program or erase sequence. Software sets a capture-enable bit. The next ordinary write to a valid array address is then held back from the array, and its address and data are stored in a pair of target latches. The stored target feeds the array's program or erase machinery, together with an erase/program mode bit and a high-voltage enable. Software times the pulses and checks the results. Those parts, and the array itself, are outside this block.

The block guards the sequence with interlocks. The high-voltage enable cannot be set until a target has been stored. While the enable is set, the mode bit and the capture-enable bit are frozen, and the stored target cannot change. A single register write that drops the enable is applied as if the enable were cleared first, so the other bits in that same write take effect at once. A read of the register returns the bits as they stand after any write that was refused.

The register fields are bit 0 for the high-voltage enable, bit 1 for capture enable and bit 2 for erase mode. Erase mode is 1 for erase and 0 for program. The read data adds bit 3, a read-only flag that shows a target is stored. The valid array window is the address range ARR_BASE up to ARR_BASE+ARR_SIZE-1. With the default parameters this is 0x4000 to 0xBFFF.

Top module: `fpe_ctrl`

## Requirements
- R1: After reset, read data is 0, the enable, mode and stored-target outputs are 0, and both target latches hold 0.
- R2: With capture enable clear (bit 1 = 0), an array write inside the window is forwarded: arr_commit is 1 in the cycle of the write, and the latches are not changed.
- R3: With capture enable set and no target stored, the first array write inside the window is not forwarded. Its address and data appear on tgt_addr and tgt_data after the clock edge, and the stored flag (read bit 3) becomes 1.
- R4: While a target is stored, further array writes are neither forwarded nor captured, and the latches hold their values.
- R5: Array writes outside the window are never captured and never forwarded. This includes the addresses just below ARR_BASE and just above the last valid address.
- R6: In erase mode (bit 2 = 1), capture works the same way for any address inside the window, including the last one. erase_mode shows bit 2.
- R7: A write that sets bit 0 takes effect only when a target is already stored and the same write keeps bit 1 set. Otherwise the enable stays 0 after the write.
- R8: While the enable is set, a write that keeps bit 0 set and clears bit 1 leaves capture enable set.
- R9: While the enable is set, a write that keeps bit 0 set and changes bit 2 leaves the mode unchanged.
- R10: A write that clears bit 0 while the enable is set drops hv_en after that edge. The same write's bit 1 and bit 2 values take effect in that same edge.
- R11: When capture enable becomes 0 (with the enable low), the stored flag clears. The latch contents are kept.
- R12: Read data is {stored flag, erase mode, capture enable, enable} in bits 3 down to 0. hv_en, erase_mode and tgt_valid track bits 0, 2 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Register write strobe |
| ctl_wr_data | input | 3 | Register write data: bit 2 erase mode, bit 1 capture enable, bit 0 high-voltage enable |
| ctl_rd_data | output | 4 | Register read data, with bit 3 as the stored-target flag |
| arr_wr_en | input | 1 | Array write cycle strobe |
| arr_wr_addr | input | AW | Array write address |
| arr_wr_data | input | DW | Array write data |
| arr_commit | output | 1 | Array write forwarded to the array (combinational) |
| tgt_addr | output | AW | Stored target address |
| tgt_data | output | DW | Stored target data |
| erase_mode | output | 1 | 1 = erase, 0 = program |
| hv_en | output | 1 | High-voltage path enable |
| tgt_valid | output | 1 | A target is stored |

## Verification
If the interlock state goes wrong, it shows on read data one edge after the register write that caused it. Examples are an enable that sets with no target stored, or a mode bit that moves while the enable is high. Each case shows up as a mismatch in bits 0 to 2 read back right after the write. A fault in the stored-target state shows in one of two ways: as a target-latch change on the edge after an array write that should have been refused, or as arr_commit staying high or low in the same cycle as the write. Every vector therefore reads back the whole register and both latches after each operation. The window edges, a refused enable and the combined clear-enable write are each driven on their own.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
    localparam int CTL_W = 3;
    localparam int RD_W  = CTL_W + 1;

    // Bit order is the register layout: erase = bit 2, capt = bit 1, arm = bit 0.
    typedef struct packed {
        logic erase;
        logic capt;
        logic arm;
    } fpe_ctl_t;

    typedef struct packed {
        fpe_ctl_t ctl;
        logic     tgt_ok;
    } fpe_state_t;
endpackage

// File: rtl/fpe_addr_window.sv
module fpe_addr_window #(
    parameter int          AW       = 16,
    parameter int unsigned ARR_BASE = 32'h4000,
    parameter int unsigned ARR_SIZE = 32'h8000
) (
    input  logic [AW-1:0] addr,
    output logic          hit
);
    localparam logic [AW:0] LO = (AW+1)'(ARR_BASE);
    localparam logic [AW:0] HI = (AW+1)'(ARR_BASE + ARR_SIZE);

    logic [AW:0] addr_x;

    always_comb begin
        addr_x = {1'b0, addr};
        hit    = (addr_x >= LO) && (addr_x < HI);
    end
endmodule

// File: rtl/fpe_ctl_regs.sv
module fpe_ctl_regs
    import fpe_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  fpe_ctl_t   wr_ctl,
    input  logic       cap_fire,
    output fpe_state_t st_q
);
    fpe_state_t st_d;
    logic       locked;

    always_comb begin
        st_d   = st_q;
        locked = st_q.ctl.arm && wr_ctl.arm;
        if (wr_en && !locked) begin
            // An enable that drops is applied first, so the rest of this write takes effect now.
            st_d.ctl.capt  = wr_ctl.capt;
            st_d.ctl.erase = wr_ctl.erase;
            st_d.ctl.arm   = st_q.ctl.arm ? 1'b0
                           : (wr_ctl.arm && wr_ctl.capt && st_q.tgt_ok);
        end
        if (cap_fire) begin
            st_d.tgt_ok = 1'b1;
        end
        if (!st_d.ctl.capt) begin
            st_d.tgt_ok = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/fpe_target_latch.sv
module fpe_target_latch #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] addr_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] data_q
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } tgt_t;

    tgt_t tgt_d, tgt_q;

    always_comb begin
        tgt_d = tgt_q;
        if (load) begin
            tgt_d.addr = addr_in;
            tgt_d.data = data_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else begin
            tgt_q <= tgt_d;
        end
    end

    assign addr_q = tgt_q.addr;
    assign data_q = tgt_q.data;
endmodule

// File: rtl/fpe_ctrl.sv
module fpe_ctrl
    import fpe_pkg::*;
#(
    parameter int          AW       = 16,
    parameter int          DW       = 8,
    parameter int unsigned ARR_BASE = 32'h4000,
    parameter int unsigned ARR_SIZE = 32'h8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr_en,
    input  logic [CTL_W-1:0] ctl_wr_data,
    output logic [RD_W-1:0]  ctl_rd_data,
    input  logic             arr_wr_en,
    input  logic [AW-1:0]    arr_wr_addr,
    input  logic [DW-1:0]    arr_wr_data,
    output logic             arr_commit,
    output logic [AW-1:0]    tgt_addr,
    output logic [DW-1:0]    tgt_data,
    output logic             erase_mode,
    output logic             hv_en,
    output logic             tgt_valid
);
    fpe_state_t st_q;
    logic       in_win;
    logic       cap_fire;

    fpe_addr_window #(
        .AW(AW), .ARR_BASE(ARR_BASE), .ARR_SIZE(ARR_SIZE)
    ) u_win (
        .addr(arr_wr_addr),
        .hit (in_win)
    );

    // Capture only the first in-window write after capture enable is set.
    always_comb begin
        cap_fire   = arr_wr_en && in_win && st_q.ctl.capt && !st_q.tgt_ok;
        arr_commit = arr_wr_en && in_win && !st_q.ctl.capt;
    end

    fpe_ctl_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ctl_wr_en),
        .wr_ctl  (fpe_ctl_t'(ctl_wr_data)),
        .cap_fire(cap_fire),
        .st_q    (st_q)
    );

    fpe_target_latch #(.AW(AW), .DW(DW)) u_tgt (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cap_fire),
        .addr_in(arr_wr_addr),
        .data_in(arr_wr_data),
        .addr_q (tgt_addr),
        .data_q (tgt_data)
    );

    assign ctl_rd_data = {st_q.tgt_ok, st_q.ctl};
    assign erase_mode  = st_q.ctl.erase;
    assign hv_en       = st_q.ctl.arm;
    assign tgt_valid   = st_q.tgt_ok;
endmodule

// File: rtl/fpe_ctrl_chk.sv
module fpe_ctrl_chk #(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_wr_en,
    input logic [2:0]    ctl_wr_data,
    input logic [3:0]    ctl_rd_data,
    input logic          arr_wr_en,
    input logic [AW-1:0] arr_wr_addr,
    input logic [DW-1:0] arr_wr_data,
    input logic [AW-1:0] tgt_addr,
    input logic [DW-1:0] tgt_data,
    input logic          erase_mode,
    input logic          hv_en,
    input logic          tgt_valid
);
    assert_arm_needs_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hv_en) |-> $past(tgt_valid) && $past(ctl_rd_data[1]));

    assert_capt_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hv_en |-> ctl_rd_data[1] && tgt_valid);

    assert_mode_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(hv_en) && hv_en |-> erase_mode == $past(erase_mode));

    assert_target_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(tgt_valid) && tgt_valid |-> tgt_addr == $past(tgt_addr) && tgt_data == $past(tgt_data));

    assert_capture_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_valid) |-> $past(arr_wr_en) && tgt_addr == $past(arr_wr_addr)
                             && tgt_data == $past(arr_wr_data));

    assert_flag_needs_capt_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_rd_data[1] |-> !tgt_valid);

    assert_drop_applies_rest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctl_wr_en) && $past(hv_en) && !$past(ctl_wr_data[0])
        |-> !hv_en && ctl_rd_data[2:1] == $past(ctl_wr_data[2:1]));
endmodule

bind fpe_ctrl fpe_ctrl_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr_en  (ctl_wr_en),
    .ctl_wr_data(ctl_wr_data),
    .ctl_rd_data(ctl_rd_data),
    .arr_wr_en  (arr_wr_en),
    .arr_wr_addr(arr_wr_addr),
    .arr_wr_data(arr_wr_data),
    .tgt_addr   (tgt_addr),
    .tgt_data   (tgt_data),
    .erase_mode (erase_mode),
    .hv_en      (hv_en),
    .tgt_valid  (tgt_valid)
);

// File: tb/fpe_ctrl_tb_top.sv
`timescale 1ns/1ps
module fpe_ctrl_tb_top;
    localparam int AW = 16;
    localparam int DW = 8;
    localparam int NV = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctl_wr_en = 1'b0;
    logic [2:0]    ctl_wr_data = '0;
    logic [3:0]    ctl_rd_data;
    logic          arr_wr_en = 1'b0;
    logic [AW-1:0] arr_wr_addr = '0;
    logic [DW-1:0] arr_wr_data = '0;
    logic          arr_commit;
    logic [AW-1:0] tgt_addr;
    logic [DW-1:0] tgt_data;
    logic          erase_mode;
    logic          hv_en;
    logic          tgt_valid;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    fpe_ctrl #(.AW(AW), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data), .ctl_rd_data(ctl_rd_data),
        .arr_wr_en(arr_wr_en), .arr_wr_addr(arr_wr_addr), .arr_wr_data(arr_wr_data),
        .arr_commit(arr_commit), .tgt_addr(tgt_addr), .tgt_data(tgt_data),
        .erase_mode(erase_mode), .hv_en(hv_en), .tgt_valid(tgt_valid)
    );

    typedef struct packed {
        logic        is_arr;
        logic [15:0] addr;
        logic [7:0]  data;     // register write data in bits 2:0 for register ops
        logic        commit;
        logic [3:0]  rd;
        logic [15:0] la;
        logic [7:0]  ld;
        logic [3:0]  req;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{1'b1, 16'h4010, 8'h11, 1'b1, 4'h0, 16'h0000, 8'h00, 4'd2},  // R2 forwarded
        '{1'b0, 16'h0000, 8'h01, 1'b0, 4'h0, 16'h0000, 8'h00, 4'd7},  // R7 no capt
        '{1'b0, 16'h0000, 8'h03, 1'b0, 4'h2, 16'h0000, 8'h00, 4'd7},  // R7 no target
        '{1'b1, 16'h2000, 8'h22, 1'b0, 4'h2, 16'h0000, 8'h00, 4'd5},  // R5 outside
        '{1'b1, 16'h4123, 8'h5A, 1'b0, 4'hA, 16'h4123, 8'h5A, 4'd3},  // R3 capture
        '{1'b1, 16'h4200, 8'h77, 1'b0, 4'hA, 16'h4123, 8'h5A, 4'd4},  // R4 second write
        '{1'b0, 16'h0000, 8'h03, 1'b0, 4'hB, 16'h4123, 8'h5A, 4'd7},  // R7 arm ok
        '{1'b0, 16'h0000, 8'h01, 1'b0, 4'hB, 16'h4123, 8'h5A, 4'd8},  // R8
        '{1'b0, 16'h0000, 8'h07, 1'b0, 4'hB, 16'h4123, 8'h5A, 4'd9},  // R9
        '{1'b1, 16'h5000, 8'h99, 1'b0, 4'hB, 16'h4123, 8'h5A, 4'd4},  // R4 armed
        '{1'b0, 16'h0000, 8'h04, 1'b0, 4'h4, 16'h4123, 8'h5A, 4'd10}, // R10 + R11
        '{1'b0, 16'h0000, 8'h06, 1'b0, 4'h6, 16'h4123, 8'h5A, 4'd6},  // R6 erase capt
        '{1'b1, 16'hBFFF, 8'hC3, 1'b0, 4'hE, 16'hBFFF, 8'hC3, 4'd6},  // R6 top edge
        '{1'b0, 16'h0000, 8'h07, 1'b0, 4'hF, 16'hBFFF, 8'hC3, 4'd12}, // R12 all set
        '{1'b0, 16'h0000, 8'h03, 1'b0, 4'hF, 16'hBFFF, 8'hC3, 4'd9},  // R9
        '{1'b0, 16'h0000, 8'h02, 1'b0, 4'hA, 16'hBFFF, 8'hC3, 4'd10}, // R10 keep capt
        '{1'b0, 16'h0000, 8'h00, 1'b0, 4'h0, 16'hBFFF, 8'hC3, 4'd11}, // R11
        '{1'b0, 16'h0000, 8'h02, 1'b0, 4'h2, 16'hBFFF, 8'hC3, 4'd12}, // R12
        '{1'b1, 16'hC000, 8'h01, 1'b0, 4'h2, 16'hBFFF, 8'hC3, 4'd5},  // R5 above
        '{1'b1, 16'h3FFF, 8'h02, 1'b0, 4'h2, 16'hBFFF, 8'hC3, 4'd5},  // R5 below
        '{1'b1, 16'h4000, 8'hA5, 1'b0, 4'hA, 16'h4000, 8'hA5, 4'd3},  // R3 low edge
        '{1'b0, 16'h0000, 8'h01, 1'b0, 4'h0, 16'h4000, 8'hA5, 4'd7},  // R7 capt dropped
        '{1'b0, 16'h0000, 8'h00, 1'b0, 4'h0, 16'h4000, 8'hA5, 4'd11}, // R11
        '{1'b1, 16'h4000, 8'h33, 1'b1, 4'h0, 16'h4000, 8'hA5, 4'd2}   // R2
    };

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_idle(input string req);
        check({28'd0, ctl_rd_data}, 32'h0, req, "read data");
        check({29'd0, hv_en, erase_mode, tgt_valid}, 32'h0, req, "enable/mode/flag");
        check({8'd0, tgt_addr, tgt_data}, 32'h0, req, "target latches");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d", VECS[i].req);
            @(negedge clk);
            if (VECS[i].is_arr) begin
                arr_wr_en   = 1'b1;
                arr_wr_addr = VECS[i].addr;
                arr_wr_data = VECS[i].data;
            end else begin
                ctl_wr_en   = 1'b1;
                ctl_wr_data = VECS[i].data[2:0];
            end
            #1;
            check({31'd0, arr_commit}, {31'd0, VECS[i].commit}, tag,
                  $sformatf("vec %0d commit", i));
            @(negedge clk);
            arr_wr_en = 1'b0;
            ctl_wr_en = 1'b0;
            #1;
            check({28'd0, ctl_rd_data}, {28'd0, VECS[i].rd}, tag,
                  $sformatf("vec %0d read data", i));
            // R12: outputs track read bits
            check({29'd0, hv_en, erase_mode, tgt_valid},
                  {29'd0, VECS[i].rd[0], VECS[i].rd[2], VECS[i].rd[3]}, tag,
                  $sformatf("vec %0d enable/mode/flag", i));
            check({8'd0, tgt_addr, tgt_data}, {8'd0, VECS[i].la, VECS[i].ld}, tag,
                  $sformatf("vec %0d latches", i));
        end

        // R1: reset while armed returns everything to zero
        @(negedge clk); ctl_wr_en = 1'b1; ctl_wr_data = 3'b010;
        @(negedge clk); ctl_wr_en = 1'b0;
        arr_wr_en = 1'b1; arr_wr_addr = 16'h6000; arr_wr_data = 8'h3C;
        @(negedge clk); arr_wr_en = 1'b0;
        ctl_wr_en = 1'b1; ctl_wr_data = 3'b011;
        @(negedge clk); ctl_wr_en = 1'b0;
        #1;
        check({31'd0, hv_en}, 32'd1, "R7", "armed before reset");
        rst_n = 1'b0;
        #1;
        check_idle("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule